// File: doc/BRIEF.md
# Fast A20 Gate

This block produces the system address bit 20 from the processor's own bit 20. Real-mode software expects addresses to wrap at the 1-Mbyte boundary, so the system bit must be held at 0 unless something opens the gate. Two things can open it. The first is an external gate input, which is usually driven by a keyboard controller and is slow to change. The second is a set of internal gate bits that software writes over the I/O bus in a single cycle.

There are two internal paths. A direct fast-gate port at I/O address 92h holds one enable bit. A configuration register is reached through an index/data port pair at index 6Fh. It holds a select bit and a gate bit, and the gate bit only counts while the select bit is set. The processor's bit 20 reaches the system bus combinationally, ANDed with the gate. The gate state itself is registered.

Top module: `a20_gate_top`

## Requirements
- R1: After reset the fast-gate bit, the configuration select and gate bits, and the index register all read 0, so the system A20 follows the external gate.
- R2: While extGate is 1, sysA20 equals cpuA20 in the same cycle.
- R3: While extGate is 0 and no internal path is open, sysA20 is 0 for any cpuA20.
- R4: Writing a byte to address 0x0092 with bit 1 set opens the fast gate from the next clock edge on, whatever extGate is. Writing bit 1 as 0 closes it.
- R5: At configuration index 0x6F, data bit 0 is the select bit and data bit 1 is the gate bit. The gate opens when both are 1. A gate bit of 1 with select 0 has no effect on sysA20.
- R6: A write to address 0x0022 loads the index register. An access to address 0x0023 reaches the configuration register only when the index is 0x6F. Other indexes ignore writes and read as 0.
- R7: A read strobe returns data on ioRdData one cycle later, and ioRdData is 0 in every cycle after a cycle without a read. Address 0x0092 returns the stored bit in bit 1 and 0 elsewhere. The configuration register returns the select bit in bit 0, the gate bit in bit 1, and 0 elsewhere. Address 0x0022 returns the index.
- R8: Reads and writes to any other address change no state and read as 0.
- R9: sysA20 is never 1 while cpuA20 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 16 | I/O address |
| ioWrData | input | 8 | Write data |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioRdData | output | 8 | Read data, valid the cycle after ioRd |
| extGate | input | 1 | External gate from the keyboard controller, 1 = pass |
| cpuA20 | input | 1 | Processor address bit 20 |
| sysA20 | output | 1 | System address bit 20 |

## Verification
The assertions assume that ioRd and ioWr are never high in the same cycle. Every access in the stimulus uses either one strobe or the other. The gate checks also assume that cpuA20 and extGate are stable when the clock edge samples them. The stimulus changes these two inputs, and the bus signals, a short delay after the rising edge and never at it.

// File: rtl/a20_gate_pkg.sv
package a20_gate_pkg;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_INDEX = 2'd1,
    RD_CFG   = 2'd2,
    RD_FAST  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   wrIndex;
    logic   wrCfg;
    logic   wrFast;
    rdSrc_e rdSrc;
  } a20Strobe_t;

endpackage

// File: rtl/a20_gate_ctrl.sv
module a20_gate_ctrl
  import a20_gate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
  parameter logic [ADDR_W-1:0] DAT_PORT  = 16'h0023,
  parameter logic [ADDR_W-1:0] FAST_PORT = 16'h0092,
  parameter logic [DATA_W-1:0] CFG_IDX   = 8'h6F
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] curIndex,
  output a20Strobe_t        strobe
);

  logic hitIdx;
  logic hitDat;
  logic hitFast;
  logic cfgSel;

  assign hitIdx  = (ioAddr == IDX_PORT);
  assign hitDat  = (ioAddr == DAT_PORT);
  assign hitFast = (ioAddr == FAST_PORT);
  assign cfgSel  = hitDat && (curIndex == CFG_IDX);

  always_comb begin
    strobe.wrIndex = ioWr && hitIdx;
    strobe.wrCfg   = ioWr && cfgSel;
    strobe.wrFast  = ioWr && hitFast;
    strobe.rdSrc   = RD_NONE;
    if (ioRd) begin
      if (hitIdx)       strobe.rdSrc = RD_INDEX;
      else if (cfgSel)  strobe.rdSrc = RD_CFG;
      else if (hitFast) strobe.rdSrc = RD_FAST;
      else              strobe.rdSrc = RD_NONE;
    end
  end

endmodule

// File: rtl/a20_gate_dp.sv
module a20_gate_dp
  import a20_gate_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FAST_BIT = 1,
  parameter int SEL_BIT  = 0,
  parameter int GATE_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  a20Strobe_t        strobe,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              extGate,
  input  logic              cpuA20,
  output logic [DATA_W-1:0] curIndex,
  output logic [DATA_W-1:0] ioRdData,
  output logic              sysA20
);

  logic              fastQ;
  logic              selQ;
  logic              gateQ;
  logic [DATA_W-1:0] indexQ;
  logic [DATA_W-1:0] rdNext;
  logic              gateOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexQ <= '0;
      fastQ  <= 1'b0;
      selQ   <= 1'b0;
      gateQ  <= 1'b0;
    end else begin
      if (strobe.wrIndex) indexQ <= ioWrData;
      if (strobe.wrFast)  fastQ  <= ioWrData[FAST_BIT];
      if (strobe.wrCfg) begin
        selQ  <= ioWrData[SEL_BIT];
        gateQ <= ioWrData[GATE_BIT];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSrc)
      RD_INDEX: rdNext = indexQ;
      RD_CFG: begin
        rdNext[SEL_BIT]  = selQ;
        rdNext[GATE_BIT] = gateQ;
      end
      RD_FAST:  rdNext[FAST_BIT] = fastQ;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ioRdData <= '0;
    else       ioRdData <= rdNext;
  end

  assign gateOpen = extGate | fastQ | (selQ & gateQ);
  assign sysA20   = cpuA20 & gateOpen;
  assign curIndex = indexQ;

endmodule

// File: rtl/a20_gate_top.sv
module a20_gate_top
  import a20_gate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0022,
  parameter logic [ADDR_W-1:0] DAT_PORT  = 16'h0023,
  parameter logic [ADDR_W-1:0] FAST_PORT = 16'h0092,
  parameter logic [DATA_W-1:0] CFG_IDX   = 8'h6F,
  parameter int FAST_BIT = 1,
  parameter int SEL_BIT  = 0,
  parameter int GATE_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  output logic [DATA_W-1:0] ioRdData,
  input  logic              extGate,
  input  logic              cpuA20,
  output logic              sysA20
);

  a20Strobe_t        strobe;
  logic [DATA_W-1:0] curIndex;

  a20_gate_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT),
    .FAST_PORT(FAST_PORT), .CFG_IDX(CFG_IDX)
  ) u_ctrl (
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .curIndex(curIndex), .strobe(strobe)
  );

  a20_gate_dp #(
    .DATA_W(DATA_W), .FAST_BIT(FAST_BIT),
    .SEL_BIT(SEL_BIT), .GATE_BIT(GATE_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioWrData(ioWrData),
    .extGate(extGate), .cpuA20(cpuA20), .curIndex(curIndex),
    .ioRdData(ioRdData), .sysA20(sysA20)
  );

endmodule

// File: rtl/a20_gate_chk.sv
module a20_gate_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] FAST_PORT = 16'h0092,
  parameter int FAST_BIT = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioWrData,
  input logic              ioWr,
  input logic              ioRd,
  input logic [DATA_W-1:0] ioRdData,
  input logic              extGate,
  input logic              cpuA20,
  input logic              sysA20
);

  localparam logic [DATA_W-1:0] FAST_MASK = DATA_W'(1) << FAST_BIT;

  // R9
  never_exceed_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysA20 |-> cpuA20);

  // R2
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    extGate |-> (sysA20 == cpuA20));

  // R4
  fast_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == FAST_PORT && ioWrData[FAST_BIT]) |=> (sysA20 == cpuA20));

  // R7
  fast_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr == FAST_PORT) |=> ((ioRdData & ~FAST_MASK) == '0));

  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |=> (ioRdData == '0));

  // R7 (input rule: one strobe per cycle)
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && ioWr));

endmodule

bind a20_gate_top a20_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAST_PORT(FAST_PORT), .FAST_BIT(FAST_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
  .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData),
  .extGate(extGate), .cpuA20(cpuA20), .sysA20(sysA20)
);

// File: tb/sim_a20_gate_top.sv
`timescale 1ns/1ps
module sim_a20_gate_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioRdData;
  logic        extGate = 1'b0;
  logic        cpuA20 = 1'b0;
  logic        sysA20;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int mIndex = 0;
  int mFast = 0;
  int mSel = 0;
  int mGate = 0;
  int mRd = 0;

  always #5 clk = ~clk;

  a20_gate_top u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData),
    .extGate(extGate), .cpuA20(cpuA20), .sysA20(sysA20)
  );

  function automatic int modelRead(int a);
    if (a == 'h22) return mIndex;
    if (a == 'h23 && mIndex == 'h6F) return mSel + 2 * mGate;
    if (a == 'h92) return 2 * mFast;
    return 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mIndex = 0; mFast = 0; mSel = 0; mGate = 0; mRd = 0;
    end else begin
      int nextRd;
      nextRd = ioRd ? modelRead(int'(ioAddr)) : 0;
      if (ioWr) begin
        if (ioAddr == 16'h0022) mIndex = int'(ioWrData);
        else if (ioAddr == 16'h0023 && mIndex == 'h6F) begin
          mSel = int'(ioWrData[0]);
          mGate = int'(ioWrData[1]);
        end else if (ioAddr == 16'h0092) mFast = int'(ioWrData[1]);
      end
      mRd = nextRd;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN) begin
      int open;
      open = (extGate || mFast != 0 || (mSel != 0 && mGate != 0)) ? 1 : 0;
      check(tag, int'(sysA20), int'(cpuA20) * open, "sysA20");
      check(tag, int'(ioRdData), mRd, "ioRdData");
      if (!cpuA20) check("R9", int'(sysA20), 0, "sysA20 with cpuA20 low");
    end
  end

  task automatic busWr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #2;
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(posedge clk); #2;
    ioWr = 1'b0;
  endtask

  task automatic busRd(logic [15:0] a);
    @(posedge clk); #2;
    ioAddr = a; ioRd = 1'b1;
    @(posedge clk); #2;
    ioRd = 1'b0;
  endtask

  task automatic pins(logic c, logic e);
    @(posedge clk); #2;
    cpuA20 = c; extGate = e;
  endtask

  task automatic sweepCpu(logic e);
    pins(1'b0, e); pins(1'b1, e); pins(1'b1, e); pins(1'b0, e); pins(1'b1, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    tag = "R1";
    pins(1'b1, 1'b0);
    @(negedge clk);
    check("R1", int'(sysA20), 0, "reset sysA20");
    busRd(16'h0092); busRd(16'h0022);
    busWr(16'h0022, 8'h6F); busRd(16'h0023);

    tag = "R2"; sweepCpu(1'b1);
    tag = "R3"; sweepCpu(1'b0);

    tag = "R4";
    busWr(16'h0092, 8'h02); sweepCpu(1'b0); busRd(16'h0092);
    busWr(16'h0092, 8'hFD); sweepCpu(1'b0); busRd(16'h0092);
    busWr(16'h0092, 8'hFF); busRd(16'h0092); sweepCpu(1'b0);
    busWr(16'h0092, 8'h00); sweepCpu(1'b0);

    tag = "R5";
    busWr(16'h0022, 8'h6F);
    busWr(16'h0023, 8'h02); sweepCpu(1'b0); busRd(16'h0023);
    busWr(16'h0023, 8'h03); sweepCpu(1'b0); busRd(16'h0023);
    busWr(16'h0023, 8'h01); sweepCpu(1'b0); busRd(16'h0023);
    busWr(16'h0023, 8'h03);

    tag = "R6";
    busWr(16'h0022, 8'h10); busWr(16'h0023, 8'h00);
    busRd(16'h0023); busRd(16'h0022); sweepCpu(1'b0);
    busWr(16'h0022, 8'h6F); busRd(16'h0023);
    busWr(16'h0023, 8'h00); sweepCpu(1'b0);

    tag = "R8";
    busWr(16'h0091, 8'hFF); busWr(16'h0192, 8'hFF); busWr(16'h0024, 8'hFF);
    busRd(16'h0091); busRd(16'h0024); sweepCpu(1'b0);
    busRd(16'h0022);

    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      int kind;
      logic [15:0] a;
      kind = int'($urandom_range(0, 5));
      case ($urandom_range(0, 4))
        0: a = 16'h0022;
        1: a = 16'h0023;
        2: a = 16'h0092;
        3: a = 16'h0093;
        default: a = 16'h0023;
      endcase
      if (kind == 0) busWr(16'h0022, ($urandom_range(0, 1) != 0) ? 8'h6F : 8'($urandom));
      else if (kind == 1) busWr(a, 8'($urandom));
      else if (kind == 2) busRd(a);
      else pins(1'($urandom), 1'($urandom));
    end

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule